// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache Controller

This block is a read-only, direct-mapped instruction cache placed between a processor fetch port and memory. Every fetch is first tested against a configurable cacheable address window. Fetches outside the window are passed unchanged to an uncached memory port, and the cache contents stay as they were. Fetches inside the window are looked up in a tag store. Each line entry holds an address tag, one valid flag for every word of the line, and one valid flag for the line as a whole.

A hit returns the stored word one cycle after the fetch is sampled. A miss drops every valid flag of the victim line, then asks a burst memory port for the whole line. The fill writes the returned words in order from word 0. The stalled fetch is answered as soon as its own word has been written. The line flag and the new tag are written on the final beat. No other fetch is accepted until the fill is complete.

With the default settings the cache holds 4 KB in 8-word lines of 32-bit words, which gives 128 lines and 1024 words. The cacheable window is 64 KB, from 0x00300000 to 0x0030FFFF. That gives a 4-bit tag. A fetch address splits, from high bits to low bits, into tag, line index, word within the line, and byte offset. The widths of these fields are derived at elaboration from the cache size, the line length and the window bounds.

Top module: `icache_ctrl`

## Requirements
- R1: A fetch whose address is below the base or above the high address raises `unc_req` one cycle after it is sampled, with `unc_addr` equal to the fetch address. `unc_req` stays high with a stable address until `unc_ack`. `fetch_ready` pulses with `unc_data` in the cycle after `unc_ack` is sampled. Cached lines are left as they were, so a line loaded earlier still hits afterwards.
- R2: A cacheable fetch hits only when the line flag is set, the addressed word's flag is set and the stored tag matches. A hit gives `fetch_ready` with the stored word one cycle after the fetch is sampled, and it issues no fill.
- R3: A cacheable miss raises `fill_req` for exactly one cycle, one cycle after the fetch is sampled. `fill_addr` is the fetch address with its word and byte bits (bits 4:0 by default) cleared.
- R4: The memory side returns one beat per `fill_valid`, in order, starting at word 0 of the line. Each beat is stored, and after the last beat every word of the line hits with the data of its own beat.
- R5: During a fill, `fetch_ready` pulses once, with `fill_data`, in the cycle after the beat of the requested word is sampled. There is exactly one `fetch_ready` pulse per fetch.
- R6: Synchronous reset (`rst` high) clears every line flag, so the first fetch after reset to any cacheable address misses. During reset `fetch_ready`, `fill_req` and `unc_req` are low.
- R7: Two addresses with the same line index but different tags evict each other. Each one misses after the other has been loaded.
- R8: The base address and the high address's last word are both cacheable. The word just below the base and the address just above the high bound are not cacheable.
- R9: A fetch presented while a fill is in progress is not looked up until the cycle after the last beat. It is then served from the completed line without a new fill.
- R10: `fill_req` and `unc_req` are never high together. An uncached fetch never raises `fill_req`, and a cacheable fetch never raises `unc_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_addr | input | ADDR_W | Byte address of the instruction |
| fetch_ready | output | 1 | One-cycle pulse: `fetch_data` is valid |
| fetch_data | output | DATA_W | Returned instruction word |
| unc_req | output | 1 | Uncached read request, held until `unc_ack` |
| unc_addr | output | ADDR_W | Uncached read address |
| unc_ack | input | 1 | Uncached read complete, `unc_data` valid |
| unc_data | input | DATA_W | Uncached read data |
| fill_req | output | 1 | One-cycle pulse requesting a full line |
| fill_addr | output | ADDR_W | Line-aligned fill address |
| fill_valid | input | 1 | One beat of fill data is valid |
| fill_data | input | DATA_W | Fill beat data, word 0 first |

## Verification
Each result has a fixed due cycle. A hit answers one cycle after the fetch is sampled. A fill request appears one cycle after a miss is sampled. An uncached answer comes one cycle after the acknowledge. A stalled fetch is answered one cycle after the beat of its own word. The bench drives inputs and samples outputs on the falling edge and counts falling edges from the request to the answer. With the bench's fixed memory delays, the counts come to 1 for a hit, 3 for an uncached fetch, 5 plus the word number for a miss, and 8 for a fetch that waits behind the rest of a fill. Each count is compared exactly, and so are the data, the number of fill pulses and the captured request addresses.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [1:0] {
        FSM_IDLE   = 2'd0,
        FSM_BYPASS = 2'd1,
        FSM_FILL   = 2'd2
    } fsm_e;

endpackage

// File: rtl/icache_addr_split.sv
module icache_addr_split #(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] LO_BOUND  = 32'h0030_0000,
    parameter logic [ADDR_W-1:0] HI_BOUND  = 32'h0030_FFFF,
    parameter int              BYTE_W    = 2,
    parameter int              WORD_W    = 3,
    parameter int              IDX_W     = 7,
    parameter int              TAG_LO    = 12,
    parameter int              TAG_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);

    // window test against both bounds, inclusive
    assign in_window = (addr >= LO_BOUND) && (addr <= HI_BOUND);

    // field slicing: tag | index | word | byte
    assign tag  = addr[TAG_LO +: TAG_W];
    assign idx  = addr[BYTE_W + WORD_W +: IDX_W];
    assign word = addr[BYTE_W +: WORD_W];

endmodule

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
    parameter int LINES  = 128,
    parameter int IDX_W  = 7,
    parameter int TAG_W  = 4,
    parameter int WORDS  = 8,
    parameter int WORD_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    // lookup side
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [WORD_W-1:0] lk_word,
    output logic              lk_hit,
    // update side
    input  logic [IDX_W-1:0]  up_idx,
    input  logic              up_inval,
    input  logic              up_word_set,
    input  logic [WORD_W-1:0] up_word_sel,
    input  logic              up_commit,
    input  logic [TAG_W-1:0]  up_tag
);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [WORDS-1:0] wvalid;
        logic             lvalid;
    } entry_t;

    logic [LINES-1:0] hit_vec;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            entry_t ent_d;
            entry_t ent_q;
            logic   sel_up;

            assign sel_up = (up_idx == IDX_W'(g));

            always_comb begin
                ent_d = ent_q;
                if (sel_up) begin
                    if (up_inval) begin
                        ent_d.wvalid = '0;
                        ent_d.lvalid = 1'b0;
                    end
                    if (up_word_set) begin
                        ent_d.wvalid[up_word_sel] = 1'b1;
                    end
                    if (up_commit) begin
                        ent_d.lvalid = 1'b1;
                        ent_d.tag    = up_tag;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q <= '0;
                end else begin
                    ent_q <= ent_d;
                end
            end

            assign hit_vec[g] = (lk_idx == IDX_W'(g)) && ent_q.lvalid &&
                                ent_q.wvalid[lk_word] && (ent_q.tag == lk_tag);
        end
    endgenerate

    assign lk_hit = |hit_vec;

    // R6: the cycle right after reset, nothing can hit
    assert_cold_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    // R7: an entry invalidated on one edge cannot hit the same index and word on the next
    assert_inval_blocks_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (up_inval && !up_commit) ##1 (lk_idx == $past(up_idx)) |-> !lk_hit);

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int ADDR_BITS = 10,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [DATA_W-1:0]    rd_data
);

    localparam int DEPTH = 1 << ADDR_BITS;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // asynchronous read, lookup completes in the request cycle
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl #(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                CACHE_BYTES = 4096,
    parameter int                LINE_WORDS  = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h0030_0000,
    parameter logic [ADDR_W-1:0] HIGH_ADDR   = 32'h0030_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              unc_req,
    output logic [ADDR_W-1:0] unc_addr,
    input  logic              unc_ack,
    input  logic [DATA_W-1:0] unc_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);

    import icache_pkg::*;

    localparam int BYTE_W  = $clog2(DATA_W / 8);
    localparam int WORD_W  = $clog2(LINE_WORDS);
    localparam int OFF_W   = $clog2(CACHE_BYTES);
    localparam int LINES   = CACHE_BYTES / (LINE_WORDS * (DATA_W / 8));
    localparam int IDX_W   = $clog2(LINES);
    localparam int WIN_W   = $clog2(int'(HIGH_ADDR - BASE_ADDR) + 1);
    localparam int TAG_W   = WIN_W - OFF_W;
    localparam int STORE_W = IDX_W + WORD_W;
    localparam int LINE_LO = BYTE_W + WORD_W;

    typedef struct packed {
        fsm_e              st;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] want;
        logic [WORD_W-1:0] beat;
        logic              rdy;
        logic [DATA_W-1:0] rdata;
        logic              fill_go;
        logic              unc_go;
    } ctrl_t;

    ctrl_t c_d, c_q;

    // lookup fields of the incoming fetch
    logic              lk_in;
    logic [TAG_W-1:0]  lk_tag;
    logic [IDX_W-1:0]  lk_idx;
    logic [WORD_W-1:0] lk_word;
    logic              lk_hit;

    // fields of the held miss address
    logic [TAG_W-1:0]  q_tag;
    logic [IDX_W-1:0]  q_idx;

    // store update controls
    logic [IDX_W-1:0]   up_idx;
    logic               up_inval;
    logic               up_word_set;
    logic               up_commit;
    logic               ds_we;
    logic [DATA_W-1:0]  ds_rdata;

    icache_addr_split #(
        .ADDR_W   (ADDR_W),
        .LO_BOUND (BASE_ADDR),
        .HI_BOUND (HIGH_ADDR),
        .BYTE_W   (BYTE_W),
        .WORD_W   (WORD_W),
        .IDX_W    (IDX_W),
        .TAG_LO   (OFF_W),
        .TAG_W    (TAG_W)
    ) u_split (
        .addr      (fetch_addr),
        .in_window (lk_in),
        .tag       (lk_tag),
        .idx       (lk_idx),
        .word      (lk_word)
    );

    assign q_tag = c_q.addr[OFF_W +: TAG_W];
    assign q_idx = c_q.addr[LINE_LO +: IDX_W];

    icache_tag_store #(
        .LINES  (LINES),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .WORDS  (LINE_WORDS),
        .WORD_W (WORD_W)
    ) u_tags (
        .clk         (clk),
        .rst         (rst),
        .lk_idx      (lk_idx),
        .lk_tag      (lk_tag),
        .lk_word     (lk_word),
        .lk_hit      (lk_hit),
        .up_idx      (up_idx),
        .up_inval    (up_inval),
        .up_word_set (up_word_set),
        .up_word_sel (c_q.beat),
        .up_commit   (up_commit),
        .up_tag      (q_tag)
    );

    icache_data_store #(
        .ADDR_BITS (STORE_W),
        .DATA_W    (DATA_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (ds_we),
        .wr_addr ({q_idx, c_q.beat}),
        .wr_data (fill_data),
        .rd_addr ({lk_idx, lk_word}),
        .rd_data (ds_rdata)
    );

    always_comb begin
        c_d         = c_q;
        c_d.rdy     = 1'b0;
        c_d.fill_go = 1'b0;
        up_idx      = (c_q.st == FSM_IDLE) ? lk_idx : q_idx;
        up_inval    = 1'b0;
        up_word_set = 1'b0;
        up_commit   = 1'b0;
        ds_we       = 1'b0;

        case (c_q.st)
            FSM_IDLE: begin
                if (fetch_req) begin
                    c_d.addr = fetch_addr;
                    if (!lk_in) begin
                        c_d.unc_go = 1'b1;
                        c_d.st     = FSM_BYPASS;
                    end else if (lk_hit) begin
                        c_d.rdy   = 1'b1;
                        c_d.rdata = ds_rdata;
                    end else begin
                        up_inval    = 1'b1;
                        c_d.fill_go = 1'b1;
                        c_d.want    = lk_word;
                        c_d.beat    = '0;
                        c_d.st      = FSM_FILL;
                    end
                end
            end

            FSM_BYPASS: begin
                if (unc_ack) begin
                    c_d.rdy    = 1'b1;
                    c_d.rdata  = unc_data;
                    c_d.unc_go = 1'b0;
                    c_d.st     = FSM_IDLE;
                end
            end

            FSM_FILL: begin
                if (fill_valid) begin
                    ds_we       = 1'b1;
                    up_word_set = 1'b1;
                    if (c_q.beat == c_q.want) begin
                        c_d.rdy   = 1'b1;
                        c_d.rdata = fill_data;
                    end
                    if (c_q.beat == WORD_W'(LINE_WORDS - 1)) begin
                        up_commit = 1'b1;
                        c_d.st    = FSM_IDLE;
                    end
                    c_d.beat = c_q.beat + 1'b1;
                end
            end

            default: begin
                c_d.st = FSM_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign fetch_ready = c_q.rdy;
    assign fetch_data  = c_q.rdata;
    assign unc_req     = c_q.unc_go;
    assign unc_addr    = c_q.addr;
    assign fill_req    = c_q.fill_go;
    assign fill_addr   = {c_q.addr[ADDR_W-1:LINE_LO], {LINE_LO{1'b0}}};

    // R1: an uncached request holds its address until acknowledged
    assert_unc_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (unc_req && !unc_ack) |=> (unc_req && $stable(unc_addr)));

    // R1: acknowledge turns into a ready pulse on the next cycle
    assert_unc_answer_R1: assert property (@(posedge clk) disable iff (rst)
        (unc_req && unc_ack) |=> (fetch_ready && !unc_req));

    // R3: a fill request lasts a single cycle and follows a fetch
    assert_fill_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> !fill_req);
    assert_fill_after_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> $past(fetch_req));

    // R9: while a fill is outstanding no second fill request appears
    assert_no_refill_R9: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == FSM_FILL) |-> !fill_req || $past(c_q.st == FSM_IDLE));

    // R10: the two memory ports never request together
    assert_port_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(fill_req && unc_req));

endmodule

// File: tb/icache_ctrl_tb_top.sv
module icache_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ready;
    logic [31:0] fetch_data;
    logic        unc_req;
    logic [31:0] unc_addr;
    logic        unc_ack;
    logic [31:0] unc_data;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic        fill_valid;
    logic [31:0] fill_data;

    int n_total = 0;
    int n_bad   = 0;

    // memory model bookkeeping
    int          fill_cnt = 0;
    int          unc_cnt  = 0;
    logic [31:0] last_fill_addr = '0;
    logic [31:0] last_unc_addr  = '0;
    logic [31:0] fb_base = '0;
    int          fb_beat = 0;
    int          fb_wait = 0;
    bit          fb_act  = 1'b0;
    int          uw      = 0;
    bit          unc_seen = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    icache_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_ready (fetch_ready),
        .fetch_data  (fetch_data),
        .unc_req     (unc_req),
        .unc_addr    (unc_addr),
        .unc_ack     (unc_ack),
        .unc_data    (unc_data),
        .fill_req    (fill_req),
        .fill_addr   (fill_addr),
        .fill_valid  (fill_valid),
        .fill_data   (fill_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0000_1234;
    endfunction

    // memory side: fills start two falling edges after the request, one beat per cycle;
    // uncached reads acknowledge on the second falling edge with the request seen
    always @(negedge clk) begin
        fill_valid = 1'b0;
        if (rst) begin
            fb_act = 1'b0; unc_ack = 1'b0; uw = 0; unc_seen = 1'b0;
        end else begin
            if (fill_req) begin
                fb_base = fill_addr; fb_beat = 0; fb_wait = 2; fb_act = 1'b1;
                fill_cnt++; last_fill_addr = fill_addr;
            end else if (fb_act) begin
                if (fb_wait > 0) begin
                    fb_wait--;
                end else begin
                    fill_valid = 1'b1;
                    fill_data  = mem_word(fb_base + 32'(4 * fb_beat));
                    fb_beat++;
                    if (fb_beat == 8) fb_act = 1'b0;
                end
            end
            if (unc_ack) begin
                unc_ack = 1'b0; uw = 0; unc_seen = 1'b0;
            end else if (unc_req) begin
                if (!unc_seen) begin
                    unc_cnt++; last_unc_addr = unc_addr; unc_seen = 1'b1;
                end
                uw++;
                if (uw >= 2) begin
                    unc_ack  = 1'b1;
                    unc_data = ~unc_addr;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, output logic [31:0] d, output int cyc);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (fetch_ready || cyc > 200) break;
        end
        d = fetch_data;
        fetch_req = 1'b0;
    endtask

    task automatic do_reset();
        fetch_req = 1'b0; fetch_addr = '0; rst = 1'b1;
        repeat (3) @(negedge clk);
        // R6: outputs idle while reset is held
        chk(!fetch_ready && !fill_req && !unc_req, "R6 idle in reset",
            {29'd0, fetch_ready, fill_req, unc_req}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_cold_miss();
        logic [31:0] d; int c; int f0;
        f0 = fill_cnt;
        do_fetch(32'h0030_0040, d, c);
        chk(d == mem_word(32'h0030_0040), "R4 miss data word0", d, mem_word(32'h0030_0040));
        chk(c == 5, "R5 miss latency word0", 32'(c), 32'd5);
        chk(fill_cnt == f0 + 1, "R3 one fill pulse", 32'(fill_cnt - f0), 32'd1);
        chk(last_fill_addr == 32'h0030_0040, "R3 aligned fill addr", last_fill_addr, 32'h0030_0040);
        @(negedge clk);
        chk(!fetch_ready, "R5 single ready pulse", {31'd0, fetch_ready}, 32'd0);
    endtask

    task automatic t_hits();
        logic [31:0] d; int c; int f0;
        f0 = fill_cnt;
        repeat (12) @(negedge clk);   // let the fill finish
        for (int w = 1; w < 8; w += 3) begin
            do_fetch(32'h0030_0040 + 32'(4 * w), d, c);
            chk(c == 1, "R2 hit latency", 32'(c), 32'd1);
            chk(d == mem_word(32'h0030_0040 + 32'(4 * w)), "R4 hit data",
                d, mem_word(32'h0030_0040 + 32'(4 * w)));
        end
        chk(fill_cnt == f0, "R2 hit issues no fill", 32'(fill_cnt - f0), 32'd0);
    endtask

    task automatic t_mid_word();
        logic [31:0] d; int c;
        do_fetch(32'h0030_0098, d, c);   // word 6 of line at 0x80
        chk(c == 11, "R5 miss latency word6", 32'(c), 32'd11);
        chk(d == mem_word(32'h0030_0098), "R5 miss data word6", d, mem_word(32'h0030_0098));
        chk(last_fill_addr == 32'h0030_0080, "R3 fill addr clears low bits",
            last_fill_addr, 32'h0030_0080);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_uncached();
        logic [31:0] d; int c; int f0; int u0;
        f0 = fill_cnt; u0 = unc_cnt;
        do_fetch(32'h0040_0040, d, c);
        chk(c == 3, "R1 uncached latency", 32'(c), 32'd3);
        chk(d == ~32'h0040_0040, "R1 uncached data", d, ~32'h0040_0040);
        chk(last_unc_addr == 32'h0040_0040, "R1 uncached addr", last_unc_addr, 32'h0040_0040);
        chk(fill_cnt == f0, "R10 no fill on uncached", 32'(fill_cnt - f0), 32'd0);
        chk(unc_cnt == u0 + 1, "R10 one uncached request", 32'(unc_cnt - u0), 32'd1);
        // cached line aliasing the same index still hits
        do_fetch(32'h0030_0044, d, c);
        chk(c == 1, "R1 cache untouched by bypass", 32'(c), 32'd1);
    endtask

    task automatic t_window();
        logic [31:0] d; int c; int f0; int u0;
        f0 = fill_cnt; u0 = unc_cnt;
        do_fetch(32'h0030_0000, d, c);
        chk(c == 5 && fill_cnt == f0 + 1, "R8 base cacheable", 32'(c), 32'd5);
        repeat (8) @(negedge clk);
        do_fetch(32'h0030_FFFC, d, c);
        chk(c == 12 && fill_cnt == f0 + 2, "R8 high word cacheable", 32'(c), 32'd12);
        chk(d == mem_word(32'h0030_FFFC), "R8 high word data", d, mem_word(32'h0030_FFFC));
        chk(unc_cnt == u0, "R10 no uncached on cacheable", 32'(unc_cnt - u0), 32'd0);
        do_fetch(32'h002F_FFFC, d, c);
        chk(c == 3 && d == ~32'h002F_FFFC, "R8 below base bypassed", d, ~32'h002F_FFFC);
        do_fetch(32'h0031_0000, d, c);
        chk(c == 3 && d == ~32'h0031_0000, "R8 above high bypassed", d, ~32'h0031_0000);
        chk(fill_cnt == f0 + 2, "R8 bypass adds no fill", 32'(fill_cnt - f0), 32'd2);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int c; int f0;
        f0 = fill_cnt;
        do_fetch(32'h0030_1040, d, c);
        chk(c == 5 && d == mem_word(32'h0030_1040), "R7 alias miss", d, mem_word(32'h0030_1040));
        repeat (8) @(negedge clk);
        do_fetch(32'h0030_0040, d, c);
        chk(c == 5, "R7 evicted line misses", 32'(c), 32'd5);
        chk(fill_cnt == f0 + 2, "R7 two fills", 32'(fill_cnt - f0), 32'd2);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_during_fill();
        int c; int f0;
        f0 = fill_cnt;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 32'h0030_0200; c = 0;
        while (1) begin
            @(negedge clk); c++;
            if (fetch_ready || c > 200) break;
        end
        chk(c == 5, "R9 first fetch latency", 32'(c), 32'd5);
        fetch_addr = 32'h0030_0214;    // word 5 of the same line, request kept high
        c = 0;
        while (1) begin
            @(negedge clk); c++;
            if (fetch_ready || c > 200) break;
        end
        chk(c == 8, "R9 waits for fill end", 32'(c), 32'd8);
        chk(fetch_data == mem_word(32'h0030_0214), "R9 data after fill",
            fetch_data, mem_word(32'h0030_0214));
        fetch_req = 1'b0;
        chk(fill_cnt == f0 + 1, "R9 no second fill", 32'(fill_cnt - f0), 32'd1);
    endtask

    task automatic t_reset_clears();
        logic [31:0] d; int c;
        do_reset();
        do_fetch(32'h0030_0040, d, c);
        chk(c == 5, "R6 miss after reset", 32'(c), 32'd5);
    endtask

    initial begin
        do_reset();
        t_cold_miss();
        t_hits();
        t_mid_word();
        t_uncached();
        t_window();
        t_conflict();
        t_during_fill();
        repeat (4) @(negedge clk);
        t_reset_clears();
        repeat (12) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule